// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process ID, virtual page number) pair into a physical frame number by searching a translation table that holds exactly one entry per physical frame. Because each entry is tied to one frame, the frame number is never stored: the slot position where the key is found is the frame number. The table is shared by every process. Each entry's tag carries both the process ID and the page number, so two processes that use the same virtual page never match each other's entries.

A lookup folds the key into a table index, reads that slot and compares its tag. When an occupied slot holds another key, the index steps forward by a fixed odd stride and the next slot is probed, one probe per clock. The search ends with a hit, with a miss at the first empty slot, or with a miss once every slot has been probed. A hit returns the frame, the physical address with the page offset passed through, the protection bits and the prior used and dirty flags. A write to an entry without write permission reports a protection fault. A separate load port lets software place an entry into any chosen slot.

Top module: `ipt_lookup`

## Requirements
- R1: After reset no slot is occupied, `req_ready` and `ld_ready` are high, `rsp_valid` is low, and `rsp_hit` and `rsp_fault` stay low in every cycle where `rsp_valid` is low.
- R2: The first probe index is the XOR of all FRAME_W-bit chunks of the key {pid, vpn}, with pid in the upper bits and the key zero-padded at the top to a multiple of FRAME_W. Equivalently, key bit b is XORed into index bit (b mod FRAME_W).
- R3: A probe hits when the slot is occupied and its stored pid and vpn both equal the request. The response then has `rsp_hit`=1, `rsp_frame` equal to the slot index, `rsp_paddr` = {frame, req_off} and `rsp_prot` equal to the stored protection bits.
- R4: When an occupied slot does not match, the next probe index is (index + STRIDE) mod 2^FRAME_W, with one probe per clock. A request accepted at a clock edge whose search ends on its k-th probe gives a one-cycle `rsp_valid` pulse after the k-th following edge.
- R5: Reaching an unoccupied slot ends the search with a miss: `rsp_hit`=0, `rsp_fault`=0, frame, protection and flags all 0, and `rsp_paddr` = {0, req_off}.
- R6: If 2^FRAME_W probes pass with no match and no empty slot, the lookup ends with a miss after exactly 2^FRAME_W probes.
- R7: An occupied slot with the same vpn but a different pid does not match, and the search continues past it.
- R8: `rsp_used` and `rsp_dirty` report an entry's flags as they were before the access. A hit sets the used flag, a hit by a write also sets the dirty flag, and a load clears both flags of its slot.
- R9: A write request that matches an entry whose protection bit WR_BIT is 0 returns `rsp_fault`=1 and `rsp_hit`=0, with the slot as frame and the stored protection and flags. The entry's flags are left unchanged.
- R10: A load is taken only while no lookup is in progress (`ld_ready`=1), and it writes the slot `ld_frame` as occupied with the given pid, vpn and protection bits. A load pulse while busy is ignored. When a load and a request arrive together while idle, the load is taken and `req_ready` is low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request is taken at this clock edge |
| req_pid | input | PID_W | Process ID of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_off | input | OFF_W | Page offset, passed to the physical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ld_valid | input | 1 | Entry load present |
| ld_ready | output | 1 | Load is taken at this clock edge (idle) |
| ld_frame | input | FRAME_W | Slot (frame) to write |
| ld_pid | input | PID_W | Process ID tag to store |
| ld_vpn | input | VPN_W | Page number tag to store |
| ld_prot | input | PROT_W | Protection bits to store |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_fault | output | 1 | Write to an entry without write permission |
| rsp_frame | output | FRAME_W | Matching slot index |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset} |
| rsp_prot | output | PROT_W | Stored protection bits of the match |
| rsp_dirty | output | 1 | Dirty flag before this access |
| rsp_used | output | 1 | Used flag before this access |

## Verification
The bench builds the block with FRAME_W=3 (eight slots), STRIDE=3, PID_W=4, VPN_W=8 and OFF_W=4. With a table this small, the bench can fill every slot to reach the probe cap, build collision chains of two and three probes from keys that fold to the same index, and drive a lookup to each slot of a full table so that every position of the stride sequence is used. A reference model computes each expected hit, frame, flag value and probe latency from the requirements alone.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PROBE = 1'b1
    } probe_state_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int PID_W = 16,
    parameter int VPN_W = 36,
    parameter int IDX_W = 12
) (
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int KEY_W  = PID_W + VPN_W;
    localparam int CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0]              key_pad;
    logic [CHUNKS-1:0][IDX_W-1:0]  fold;

    assign key_pad = PAD_W'({pid, vpn});
    assign fold[0] = key_pad[IDX_W-1:0];

    // Running XOR across the chunks of the padded key
    for (genvar g = 1; g < CHUNKS; g++) begin : g_fold
        assign fold[g] = fold[g-1] ^ key_pad[g*IDX_W +: IDX_W];
    end

    assign idx = fold[CHUNKS-1];

endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
    parameter int IDX_W  = 12,
    parameter int PID_W  = 16,
    parameter int VPN_W  = 36,
    parameter int PROT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    // install port
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PID_W-1:0]  ld_pid,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [PROT_W-1:0] ld_prot,
    // probe read port
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_resident,
    output logic [PID_W-1:0]  rd_pid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [PROT_W-1:0] rd_prot,
    output logic              rd_dirty,
    output logic              rd_used,
    // flag update on hit
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic              mark_dirty
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0] res;
        logic [ENTRIES-1:0] dirty;
        logic [ENTRIES-1:0] used;
    } flags_t;

    flags_t flags_d, flags_q;

    logic [PID_W-1:0]  pid_mem  [ENTRIES];
    logic [VPN_W-1:0]  vpn_mem  [ENTRIES];
    logic [PROT_W-1:0] prot_mem [ENTRIES];

    always_comb begin
        flags_d = flags_q;
        if (ld_en) begin
            flags_d.res[ld_idx]   = 1'b1;
            flags_d.dirty[ld_idx] = 1'b0;
            flags_d.used[ld_idx]  = 1'b0;
        end
        if (mark_en) begin
            flags_d.used[mark_idx] = 1'b1;
            if (mark_dirty) begin
                flags_d.dirty[mark_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // Tag and protection arrays carry no reset; the resident flag gates them
    always_ff @(posedge clk) begin
        if (ld_en) begin
            pid_mem[ld_idx]  <= ld_pid;
            vpn_mem[ld_idx]  <= ld_vpn;
            prot_mem[ld_idx] <= ld_prot;
        end
    end

    assign rd_resident = flags_q.res[rd_idx];
    assign rd_dirty    = flags_q.dirty[rd_idx];
    assign rd_used     = flags_q.used[rd_idx];
    assign rd_pid      = pid_mem[rd_idx];
    assign rd_vpn      = vpn_mem[rd_idx];
    assign rd_prot     = prot_mem[rd_idx];

endmodule

// File: rtl/ipt_probe_fsm.sv
module ipt_probe_fsm
    import ipt_pkg::*;
#(
    parameter int PID_W  = 16,
    parameter int VPN_W  = 36,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 12,
    parameter int PROT_W = 3,
    parameter int WR_BIT = 1,
    parameter int STRIDE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  hash_idx,
    input  logic              ld_valid,
    output logic              ld_ready,
    output logic              ld_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_resident,
    input  logic [PID_W-1:0]  rd_pid,
    input  logic [VPN_W-1:0]  rd_vpn,
    input  logic [PROT_W-1:0] rd_prot,
    input  logic              rd_dirty,
    input  logic              rd_used,
    output logic              mark_en,
    output logic [IDX_W-1:0]  mark_idx,
    output logic              mark_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [IDX_W-1:0]  rsp_frame,
    output logic [OFF_W-1:0]  rsp_off,
    output logic [PROT_W-1:0] rsp_prot,
    output logic              rsp_dirty,
    output logic              rsp_used
);
    localparam logic [IDX_W-1:0] STEP     = IDX_W'(STRIDE);
    localparam logic [IDX_W-1:0] LAST_CNT = '1;

    typedef struct packed {
        probe_state_e       state;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   cnt;
        logic [PID_W-1:0]   pid;
        logic [VPN_W-1:0]   vpn;
        logic [OFF_W-1:0]   off;
        logic               wr;
        logic               rsp_valid;
        logic               rsp_hit;
        logic               rsp_fault;
        logic [IDX_W-1:0]   rsp_frame;
        logic [PROT_W-1:0]  rsp_prot;
        logic               rsp_dirty;
        logic               rsp_used;
    } fsm_t;

    fsm_t s_d, s_q;
    logic tag_eq;

    assign tag_eq = rd_resident && (rd_pid == s_q.pid) && (rd_vpn == s_q.vpn);

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_hit   = 1'b0;
        s_d.rsp_fault = 1'b0;
        mark_en       = 1'b0;
        mark_dirty    = 1'b0;

        ld_ready  = (s_q.state == ST_IDLE);
        req_ready = ld_ready && !ld_valid;
        ld_en     = ld_valid && ld_ready;

        case (s_q.state)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    s_d.state = ST_PROBE;
                    s_d.idx   = hash_idx;
                    s_d.cnt   = '0;
                    s_d.pid   = req_pid;
                    s_d.vpn   = req_vpn;
                    s_d.off   = req_off;
                    s_d.wr    = req_write;
                end
            end
            ST_PROBE: begin
                if (tag_eq) begin
                    s_d.state     = ST_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_frame = s_q.idx;
                    s_d.rsp_prot  = rd_prot;
                    s_d.rsp_dirty = rd_dirty;
                    s_d.rsp_used  = rd_used;
                    if (s_q.wr && !rd_prot[WR_BIT]) begin
                        s_d.rsp_fault = 1'b1;
                    end else begin
                        s_d.rsp_hit = 1'b1;
                        mark_en     = 1'b1;
                        mark_dirty  = s_q.wr;
                    end
                end else if (!rd_resident || (s_q.cnt == LAST_CNT)) begin
                    s_d.state     = ST_IDLE;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_frame = '0;
                    s_d.rsp_prot  = '0;
                    s_d.rsp_dirty = 1'b0;
                    s_d.rsp_used  = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + STEP;
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx    = s_q.idx;
    assign mark_idx  = s_q.idx;
    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_fault = s_q.rsp_fault;
    assign rsp_frame = s_q.rsp_frame;
    assign rsp_off   = s_q.off;
    assign rsp_prot  = s_q.rsp_prot;
    assign rsp_dirty = s_q.rsp_dirty;
    assign rsp_used  = s_q.rsp_used;

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int PID_W   = 16,
    parameter int VPN_W   = 36,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12,
    parameter int PROT_W  = 3,
    parameter int WR_BIT  = 1,
    parameter int STRIDE  = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [PID_W-1:0]         req_pid,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [OFF_W-1:0]         req_off,
    input  logic                     req_write,
    input  logic                     ld_valid,
    output logic                     ld_ready,
    input  logic [FRAME_W-1:0]       ld_frame,
    input  logic [PID_W-1:0]         ld_pid,
    input  logic [VPN_W-1:0]         ld_vpn,
    input  logic [PROT_W-1:0]        ld_prot,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_fault,
    output logic [FRAME_W-1:0]       rsp_frame,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic [PROT_W-1:0]        rsp_prot,
    output logic                     rsp_dirty,
    output logic                     rsp_used
);
    logic [FRAME_W-1:0] hash_idx;
    logic               ld_en;
    logic [FRAME_W-1:0] rd_idx;
    logic               rd_resident;
    logic [PID_W-1:0]   rd_pid;
    logic [VPN_W-1:0]   rd_vpn;
    logic [PROT_W-1:0]  rd_prot;
    logic               rd_dirty;
    logic               rd_used;
    logic               mark_en;
    logic [FRAME_W-1:0] mark_idx;
    logic               mark_dirty;
    logic [OFF_W-1:0]   rsp_off;

    ipt_hash #(
        .PID_W (PID_W),
        .VPN_W (VPN_W),
        .IDX_W (FRAME_W)
    ) u_hash (
        .pid (req_pid),
        .vpn (req_vpn),
        .idx (hash_idx)
    );

    ipt_store #(
        .IDX_W  (FRAME_W),
        .PID_W  (PID_W),
        .VPN_W  (VPN_W),
        .PROT_W (PROT_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_en       (ld_en),
        .ld_idx      (ld_frame),
        .ld_pid      (ld_pid),
        .ld_vpn      (ld_vpn),
        .ld_prot     (ld_prot),
        .rd_idx      (rd_idx),
        .rd_resident (rd_resident),
        .rd_pid      (rd_pid),
        .rd_vpn      (rd_vpn),
        .rd_prot     (rd_prot),
        .rd_dirty    (rd_dirty),
        .rd_used     (rd_used),
        .mark_en     (mark_en),
        .mark_idx    (mark_idx),
        .mark_dirty  (mark_dirty)
    );

    ipt_probe_fsm #(
        .PID_W  (PID_W),
        .VPN_W  (VPN_W),
        .OFF_W  (OFF_W),
        .IDX_W  (FRAME_W),
        .PROT_W (PROT_W),
        .WR_BIT (WR_BIT),
        .STRIDE (STRIDE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_pid     (req_pid),
        .req_vpn     (req_vpn),
        .req_off     (req_off),
        .req_write   (req_write),
        .hash_idx    (hash_idx),
        .ld_valid    (ld_valid),
        .ld_ready    (ld_ready),
        .ld_en       (ld_en),
        .rd_idx      (rd_idx),
        .rd_resident (rd_resident),
        .rd_pid      (rd_pid),
        .rd_vpn      (rd_vpn),
        .rd_prot     (rd_prot),
        .rd_dirty    (rd_dirty),
        .rd_used     (rd_used),
        .mark_en     (mark_en),
        .mark_idx    (mark_idx),
        .mark_dirty  (mark_dirty),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_fault   (rsp_fault),
        .rsp_frame   (rsp_frame),
        .rsp_off     (rsp_off),
        .rsp_prot    (rsp_prot),
        .rsp_dirty   (rsp_dirty),
        .rsp_used    (rsp_used)
    );

    assign rsp_paddr = {rsp_frame, rsp_off};

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int FRAME_W = 12,
    parameter int OFF_W   = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [OFF_W-1:0]         req_off,
    input logic                     ld_valid,
    input logic                     ld_ready,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic                     rsp_fault,
    input logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
    localparam int ENTRIES = 1 << FRAME_W;

    logic [OFF_W-1:0]   off_seen;
    logic [FRAME_W+1:0] busy_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_seen <= '0;
            busy_cyc <= '0;
        end else begin
            if (req_valid && req_ready) begin
                off_seen <= req_off;
            end
            busy_cyc <= ld_ready ? '0 : busy_cyc + 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !ld_ready);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr[OFF_W-1:0] == off_seen));

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !rsp_hit);

    // R6
    probe_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cyc <= (FRAME_W+2)'(ENTRIES));

    // R10
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |-> !req_ready);

endmodule

bind ipt_lookup ipt_lookup_chk #(
    .FRAME_W (FRAME_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_off),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/ipt_lookup_tb_top.sv
`timescale 1ns/1ps
module ipt_lookup_tb_top;
    localparam int PID_W   = 4;
    localparam int VPN_W   = 8;
    localparam int OFF_W   = 4;
    localparam int FRAME_W = 3;
    localparam int PROT_W  = 3;
    localparam int WR_BIT  = 1;
    localparam int STRIDE  = 3;
    localparam int ENTRIES = 1 << FRAME_W;
    localparam int KEY_W   = PID_W + VPN_W;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     req_valid = 1'b0;
    logic                     req_ready;
    logic [PID_W-1:0]         req_pid = '0;
    logic [VPN_W-1:0]         req_vpn = '0;
    logic [OFF_W-1:0]         req_off = '0;
    logic                     req_write = 1'b0;
    logic                     ld_valid = 1'b0;
    logic                     ld_ready;
    logic [FRAME_W-1:0]       ld_frame = '0;
    logic [PID_W-1:0]         ld_pid = '0;
    logic [VPN_W-1:0]         ld_vpn = '0;
    logic [PROT_W-1:0]        ld_prot = '0;
    logic                     rsp_valid;
    logic                     rsp_hit;
    logic                     rsp_fault;
    logic [FRAME_W-1:0]       rsp_frame;
    logic [FRAME_W+OFF_W-1:0] rsp_paddr;
    logic [PROT_W-1:0]        rsp_prot;
    logic                     rsp_dirty;
    logic                     rsp_used;

    always #5 clk = ~clk;

    ipt_lookup #(
        .PID_W (PID_W), .VPN_W (VPN_W), .OFF_W (OFF_W), .FRAME_W (FRAME_W),
        .PROT_W (PROT_W), .WR_BIT (WR_BIT), .STRIDE (STRIDE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_pid (req_pid),
        .req_vpn (req_vpn), .req_off (req_off), .req_write (req_write),
        .ld_valid (ld_valid), .ld_ready (ld_ready), .ld_frame (ld_frame),
        .ld_pid (ld_pid), .ld_vpn (ld_vpn), .ld_prot (ld_prot),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_fault (rsp_fault),
        .rsp_frame (rsp_frame), .rsp_paddr (rsp_paddr), .rsp_prot (rsp_prot),
        .rsp_dirty (rsp_dirty), .rsp_used (rsp_used)
    );

    typedef struct packed {
        logic                     hit;
        logic                     fault;
        logic [FRAME_W+OFF_W-1:0] paddr;
        logic [PROT_W-1:0]        prot;
        logic                     dirty;
        logic                     used;
        logic [15:0]              lat;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int acc_edge = 0;
    bit done     = 1'b0;

    // Reference table
    logic              m_res   [ENTRIES];
    logic [PID_W-1:0]  m_pid   [ENTRIES];
    logic [VPN_W-1:0]  m_vpn   [ENTRIES];
    logic [PROT_W-1:0] m_prot  [ENTRIES];
    logic              m_dirty [ENTRIES];
    logic              m_used  [ENTRIES];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FRAME_W-1:0] ref_hash(input logic [PID_W-1:0] p,
                                                    input logic [VPN_W-1:0] v);
        logic [KEY_W-1:0]   k;
        logic [FRAME_W-1:0] h;
        k = {p, v};
        h = '0;
        for (int b = 0; b < KEY_W; b++) h[b % FRAME_W] ^= k[b];
        return h;
    endfunction

    task automatic model_lookup(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                                input logic [OFF_W-1:0] o, input logic w, output exp_t e);
        logic [FRAME_W-1:0] idx;
        idx = ref_hash(p, v);
        e = '0;
        e.paddr = {{FRAME_W{1'b0}}, o};
        for (int n = 1; n <= ENTRIES; n++) begin
            e.lat = 16'(n);
            if (!m_res[idx]) break;
            if (m_pid[idx] == p && m_vpn[idx] == v) begin
                e.paddr = {idx, o};
                e.prot  = m_prot[idx];
                e.dirty = m_dirty[idx];
                e.used  = m_used[idx];
                if (w && !m_prot[idx][WR_BIT]) begin
                    e.fault = 1'b1;
                end else begin
                    e.hit = 1'b1;
                    m_used[idx] = 1'b1;
                    if (w) m_dirty[idx] = 1'b1;
                end
                break;
            end
            idx = idx + FRAME_W'(STRIDE);
        end
    endtask

    // Monitor: sampled at the falling edge, inputs change after rising edges
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected response", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rsp_hit, rsp_fault} == {e.hit, e.fault}, t, "hit/fault",
                    {rsp_hit, rsp_fault}, {e.hit, e.fault});
                chk(rsp_paddr == e.paddr, t, "paddr", rsp_paddr, e.paddr);
                chk(rsp_frame == e.paddr[FRAME_W+OFF_W-1:OFF_W], t, "frame",
                    rsp_frame, e.paddr[FRAME_W+OFF_W-1:OFF_W]);
                chk((cyc - acc_edge) == int'(e.lat), t, "latency R4",
                    cyc - acc_edge, e.lat);
                chk({rsp_prot, rsp_dirty, rsp_used} == {e.prot, e.dirty, e.used},
                    t, "prot/dirty/used R8", {rsp_prot, rsp_dirty, rsp_used},
                    {e.prot, e.dirty, e.used});
            end
        end
        if (rst_n && req_valid && req_ready) acc_edge = cyc + 1;
    end

    // Caller is at rising edge + 2
    task automatic send_req(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                            input logic [OFF_W-1:0] o, input logic w, input string t);
        exp_t e;
        model_lookup(p, v, o, w, e);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req_pid = p; req_vpn = v; req_off = o; req_write = w;
        req_valid = 1'b1;
    endtask

    task automatic wait_accept();
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic lookup(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                          input logic [OFF_W-1:0] o, input logic w, input string t);
        @(posedge clk); #2;
        send_req(p, v, o, w, t);
        wait_accept();
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_load(input logic [FRAME_W-1:0] f, input logic [PID_W-1:0] p,
                              input logic [VPN_W-1:0] v, input logic [PROT_W-1:0] pr);
        m_res[f] = 1'b1; m_pid[f] = p; m_vpn[f] = v; m_prot[f] = pr;
        m_dirty[f] = 1'b0; m_used[f] = 1'b0;
    endtask

    task automatic load(input logic [FRAME_W-1:0] f, input logic [PID_W-1:0] p,
                        input logic [VPN_W-1:0] v, input logic [PROT_W-1:0] pr);
        @(posedge clk); #2;
        ld_frame = f; ld_pid = p; ld_vpn = v; ld_prot = pr; ld_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (ld_ready) break;
        end
        @(posedge clk); #2;
        ld_valid = 1'b0;
        model_load(f, p, v, pr);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R4 act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [FRAME_W-1:0] hk;
        for (int i = 0; i < ENTRIES; i++) begin
            m_res[i] = 1'b0; m_pid[i] = '0; m_vpn[i] = '0;
            m_prot[i] = '0; m_dirty[i] = 1'b0; m_used[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(ld_ready == 1'b1, "R1", "ld_ready", ld_ready, 1);
        chk({rsp_valid, rsp_hit, rsp_fault} == 3'b000, "R1", "rsp flags",
            {rsp_valid, rsp_hit, rsp_fault}, 0);

        // R1 / R5: empty table misses on the first probe
        lookup(4'd1, 8'h25, 4'h6, 1'b0, "R5");
        drain();

        // R2 / R3: entry at its home slot hits on the first probe
        load(ref_hash(4'd1, 8'h25), 4'd1, 8'h25, 3'b011);
        lookup(4'd1, 8'h25, 4'h9, 1'b0, "R3");
        drain();
        // R8: used flag now set, write sets dirty
        lookup(4'd1, 8'h25, 4'h1, 1'b0, "R8");
        drain();
        lookup(4'd1, 8'h25, 4'h2, 1'b1, "R8");
        drain();
        lookup(4'd1, 8'h25, 4'h3, 1'b0, "R8");
        drain();

        // R7: same vpn, other pid at the home slot; search moves on and misses
        hk = ref_hash(4'd2, 8'h40);
        load(hk, 4'd3, 8'h40, 3'b111);
        lookup(4'd2, 8'h40, 4'h4, 1'b0, "R7");
        drain();
        // R4: two- and three-probe chains; 8'h49 folds to the same index as 8'h40
        load(hk + FRAME_W'(STRIDE), 4'd2, 8'h40, 3'b101);
        lookup(4'd2, 8'h40, 4'h5, 1'b0, "R4");
        drain();
        chk(ref_hash(4'd2, 8'h49) == hk, "R2", "collision key", ref_hash(4'd2, 8'h49), hk);
        load(hk + FRAME_W'(2 * STRIDE), 4'd2, 8'h49, 3'b110);
        lookup(4'd2, 8'h49, 4'h7, 1'b1, "R4");
        drain();

        // R9: write to a read-only entry faults; flags stay clear
        load(ref_hash(4'd7, 8'h13), 4'd7, 8'h13, 3'b001);
        lookup(4'd7, 8'h13, 4'h8, 1'b1, "R9");
        drain();
        lookup(4'd7, 8'h13, 4'h8, 1'b0, "R9");
        drain();
        lookup(4'd7, 8'h13, 4'hA, 1'b1, "R9");
        drain();

        // R10: a load pulse while a lookup is busy is ignored
        lookup(4'd2, 8'h49, 4'hB, 1'b0, "R4");
        ld_frame = ref_hash(4'd6, 8'h77); ld_pid = 4'd6; ld_vpn = 8'h77;
        ld_prot = 3'b111; ld_valid = 1'b1;
        @(negedge clk);
        chk(ld_ready == 1'b0, "R10", "ld_ready while busy", ld_ready, 0);
        @(posedge clk); #2;
        ld_valid = 1'b0;
        drain();
        lookup(4'd6, 8'h77, 4'hC, 1'b0, "R10");
        drain();

        // R10: load and request together while idle; load goes first
        @(posedge clk); #2;
        ld_frame = ref_hash(4'd5, 8'h5A); ld_pid = 4'd5; ld_vpn = 8'h5A;
        ld_prot = 3'b010; ld_valid = 1'b1;
        model_load(ref_hash(4'd5, 8'h5A), 4'd5, 8'h5A, 3'b010);
        send_req(4'd5, 8'h5A, 4'hD, 1'b0, "R10");
        @(negedge clk);
        chk(req_ready == 1'b0, "R10", "req_ready with load", req_ready, 0);
        @(posedge clk); #2;
        ld_valid = 1'b0;
        wait_accept();
        drain();

        // R8 / R10: reload of a used slot clears its flags
        load(ref_hash(4'd1, 8'h25), 4'd1, 8'h25, 3'b000);
        lookup(4'd1, 8'h25, 4'hE, 1'b0, "R8");
        drain();

        // R6: full table, absent key probes every slot then misses
        for (int i = 0; i < ENTRIES; i++) load(FRAME_W'(i), 4'd9, 8'h80 + 8'(i), 3'b011);
        lookup(4'd1, 8'h25, 4'hF, 1'b0, "R6");
        drain();
        // R2 / R4: each slot of the full table reached at its stride position
        for (int i = 0; i < ENTRIES; i++) begin
            lookup(4'd9, 8'h80 + 8'(i), 4'(i), 1'b0, "R4");
            drain();
        end

        finish_run();
    end

endmodule